// File: doc/BRIEF.md
# SPI Host Register Front End

This block sits between a 32-bit register bus and a separate serial shifting engine of an SPI master. Software programs the control word and an inter-transfer delay, queues bytes for transmission in a transmit FIFO and collects received bytes from a receive FIFO. The engine sees the control fields, a run bit and a valid/take handshake on the transmit side. On the receive side it has a push strobe.

Seven status conditions are kept. Three are sticky error flags that software clears by writing ones. Four are level flags that follow the FIFO fill state. A mask, changed through separate set and clear registers and read back through a third, selects which status bits drive the single interrupt line. The run bit gates all transmit activity towards the engine.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the status register (byte offset 0x04) reads 0x06, the mask register (0x10) reads 0, the enable register (0x14) reads 0, and both irq and tx_valid are 0.
- R2: The control register (0x00) returns the low 16 bits last written and drives them on ctrl. The delay register (0x18) returns all 32 bits last written and drives them on gap_cfg. The enable register (0x14) keeps bit 0 only.
- R3: A write to offset 0x1C pushes bits 7:0 into the transmit FIFO, which holds 128 bytes. The engine receives the bytes on tx_byte in the order written, one per cycle in which tx_valid and tx_take are both high.
- R4: A write to 0x1C while the transmit FIFO holds 128 bytes is dropped, and status bit 3 becomes 1.
- R5: A read of offset 0x20 returns the oldest received byte in bits 7:0 with the upper bits 0, and removes that byte. A read of an empty receive FIFO returns 0, changes no stored byte and sets status bit 6.
- R6: An rx_push while the receive FIFO holds 128 bytes is dropped, and status bit 0 becomes 1.
- R7: Status bits 0, 3 and 6 stay set until a write to 0x04 with a one in that bit position. Writes to 0x04 have no effect on bits 1, 2, 4 and 5.
- R8: Writing ones to 0x08 sets those mask bits, writing ones to 0x0C clears them, and the register at 0x10 reads back the current 7-bit mask.
- R9: irq is 1 exactly when some status bit is 1 and its mask bit is 1.
- R10: While enable bit 0 is 0, tx_valid is 0 and tx_take removes nothing from the transmit FIFO. The run output equals enable bit 0.
- R11: The level status bits are: bit 1 for transmit FIFO empty, bit 2 for transmit FIFO not full, bit 4 for receive FIFO not empty, and bit 5 for receive FIFO full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the pop side effect) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq | output | 1 | Interrupt request |
| ctrl | output | 16 | Control word to the engine |
| run | output | 1 | Controller enabled |
| gap_cfg | output | 32 | Delay setting to the engine |
| tx_valid | output | 1 | Transmit byte available and run set |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Engine consumes tx_byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |

## Verification
The hardest states to reach from the ports are the two FIFO-full conditions and the overflow flags behind them. Each needs 128 accepted pushes with no pop in between, and a random mix of operations almost never produces that. The bench therefore fills each FIFO on purpose, pushes past the limit, and checks that the dropped byte leaves no trace in the data that drains afterwards. A long random phase interleaves pushes, pops, clears of status bits, mask changes and toggles of the run bit. In that phase, takes issued while the run bit is off show that nothing is lost.

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int DEPTH  = 128,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [CTRL_W-1:0] ctrl,
  output logic              run,
  output logic [31:0]       gap_cfg,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_take,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [7:0] A_CTL = 8'h00, A_STA = 8'h04, A_SET = 8'h08, A_CLR = 8'h0C,
                         A_MSK = 8'h10, A_ENA = 8'h14, A_GAP = 8'h18, A_TXD = 8'h1C,
                         A_RXD = 8'h20;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [6:0]    mask, status;
  logic          rx_ovf, tx_ovf, rx_und;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;

  wire wr_txd  = bus_wr && bus_addr == A_TXD;
  wire rd_rxd  = bus_rd && bus_addr == A_RXD;
  wire tx_push = wr_txd && !tx_full;
  wire tx_pop  = tx_valid && tx_take;
  wire rx_in   = rx_push && !rx_full;
  wire rx_pop  = rd_rxd && !rx_empty;
  wire sta_wr  = bus_wr && bus_addr == A_STA;

  assign tx_valid = run && !tx_empty;
  assign tx_byte  = tx_mem[tx_rp];
  assign status   = {rx_und, rx_full, !rx_empty, tx_ovf, !tx_full, tx_empty, rx_ovf};
  assign irq      = |(status & mask);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_in)   rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_in)   rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; gap_cfg <= '0; run <= 1'b0; mask <= '0;
      rx_ovf <= 1'b0; tx_ovf <= 1'b0; rx_und <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTL) ctrl <= bus_wdata[CTRL_W-1:0];
      if (bus_wr && bus_addr == A_GAP) gap_cfg <= bus_wdata;
      if (bus_wr && bus_addr == A_ENA) run <= bus_wdata[0];
      if (bus_wr && bus_addr == A_SET) mask <= mask | bus_wdata[6:0];
      if (bus_wr && bus_addr == A_CLR) mask <= mask & ~bus_wdata[6:0];
      rx_ovf <= (rx_push && rx_full) || (rx_ovf && !(sta_wr && bus_wdata[0]));
      tx_ovf <= (wr_txd && tx_full)  || (tx_ovf && !(sta_wr && bus_wdata[3]));
      rx_und <= (rd_rxd && rx_empty) || (rx_und && !(sta_wr && bus_wdata[6]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTL:   bus_rdata = 32'(ctrl);
        A_STA:   bus_rdata = {25'd0, status};
        A_MSK:   bus_rdata = {25'd0, mask};
        A_ENA:   bus_rdata = {31'd0, run};
        A_GAP:   bus_rdata = gap_cfg;
        A_RXD:   bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_mem[rx_rp]};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_host_regs_chk.sv
module spi_host_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic        run,
  input logic        tx_valid,
  input logic        tx_full,
  input logic [6:0]  mask,
  input logic [6:0]  status
);
  AST_OFF_NO_TX: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !tx_valid); // R10
  AST_TX_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 8'h1C && tx_full |=> status[3]); // R4
  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 8'h20 && !status[4] |-> bus_rdata == 32'd0); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) mask == 7'd0 |-> !irq); // R9
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 8'h08 |=> (mask & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0])); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] && !(bus_wr && bus_addr == 8'h04 && bus_wdata[3]) |=> status[3]); // R7
endmodule

bind spi_host_regs spi_host_regs_chk u_chk (.*);

// File: tb/spi_host_regs_test.sv
module spi_host_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, tx_take = 0, rx_push = 0;
  logic [7:0] bus_addr = 0, rx_byte = 0, tx_byte;
  logic [31:0] bus_wdata = 0, bus_rdata, gap_cfg;
  logic [15:0] ctrl;
  logic irq, run, tx_valid;

  int total = 0, bad = 0;
  logic [7:0] txq[$], rxq[$];
  logic m_rxovf = 0, m_txovf = 0, m_rxund = 0, m_run = 0;
  logic [6:0] m_mask = 0;

  spi_host_regs uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_stat();
    return {m_rxund, rxq.size() == DEPTH, rxq.size() != 0, m_txovf,
            txq.size() != DEPTH, txq.size() == 0, m_rxovf};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    if (txq.size() == DEPTH) m_txovf = 1; else txq.push_back(b);
    wr(8'h1C, {24'hABCDEF, b});
  endtask

  task automatic pop_rx(input string tag);
    logic [31:0] d; logic [31:0] e;
    if (rxq.size() == 0) begin e = 0; m_rxund = 1; end else e = {24'd0, rxq.pop_front()};
    rd(8'h20, d); chk(tag, d, e);
  endtask

  task automatic eng_push(input logic [7:0] b);
    if (rxq.size() == DEPTH) m_rxovf = 1; else rxq.push_back(b);
    rx_push = 1; rx_byte = b; @(negedge clk); rx_push = 0;
  endtask

  task automatic eng_take(input string tag);
    logic v; v = m_run && txq.size() != 0;
    chk({tag, " valid"}, 32'(tx_valid), 32'(v));
    if (v) chk({tag, " byte"}, 32'(tx_byte), 32'(txq.pop_front()));
    tx_take = 1; @(negedge clk); tx_take = 0;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] d;
    rd(8'h04, d); chk({tag, " status"}, d, {25'd0, exp_stat()});
    chk({tag, " irq"}, 32'(irq), 32'(|(exp_stat() & m_mask)));
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1
    rd(8'h04, d); chk("R1 status", d, 32'h06);
    rd(8'h10, d); chk("R1 mask", d, 0);
    rd(8'h14, d); chk("R1 enable", d, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    // R2
    wr(8'h00, 32'h1234_BEEF); rd(8'h00, d); chk("R2 ctrl read", d, 32'h0000_BEEF);
    chk("R2 ctrl pin", 32'(ctrl), 32'h0000_BEEF);
    wr(8'h18, 32'hCAFE_0042); rd(8'h18, d); chk("R2 gap read", d, 32'hCAFE_0042);
    chk("R2 gap pin", gap_cfg, 32'hCAFE_0042);
    wr(8'h14, 32'hFFFF_FFFE); rd(8'h14, d); chk("R2 enable bit0 only", d, 0);
    // R8 / R9
    wr(8'h08, 32'h0000_0046); m_mask = 7'h46;
    rd(8'h10, d); chk("R8 mask set", d, 32'h46);
    chk("R9 irq tx empty unmasked", 32'(irq), 1);
    wr(8'h0C, 32'h0000_0006); m_mask = 7'h40;
    rd(8'h10, d); chk("R8 mask clear", d, 32'h40);
    chk("R9 irq masked", 32'(irq), 0);
    // R5 empty read
    pop_rx("R5 empty read");
    check_state("R5 underflow flag");
    // R7 clear sticky, level bits untouched
    wr(8'h04, 32'h0000_007F); m_rxund = 0;
    check_state("R7 w1c");
    // R10 take while off
    push_tx(8'h5A); push_tx(8'hA5);
    eng_take("R10 off take");
    check_state("R10 nothing removed");
    chk("R10 run pin", 32'(run), 0);
    wr(8'h14, 1); m_run = 1;
    chk("R10 run on", 32'(run), 1);
    eng_take("R3 first"); eng_take("R3 second"); eng_take("R3 empty");
    check_state("R11 tx empty again");
    // R4 fill transmit FIFO
    wr(8'h14, 0); m_run = 0;
    for (int i = 0; i < DEPTH; i++) push_tx(8'(i * 3));
    check_state("R11 tx full");
    push_tx(8'hEE);
    check_state("R4 overflow flag");
    wr(8'h14, 1); m_run = 1;
    for (int i = 0; i < DEPTH + 1; i++) eng_take("R4 drain order");
    wr(8'h04, 32'h8); m_txovf = 0;
    check_state("R7 tx ovf cleared");
    // R6 fill receive FIFO
    for (int i = 0; i < DEPTH; i++) eng_push(8'(255 - i));
    check_state("R11 rx full");
    eng_push(8'h77);
    check_state("R6 overflow flag");
    for (int i = 0; i < DEPTH + 1; i++) pop_rx("R5 drain order");
    wr(8'h04, 32'h41); m_rxovf = 0; m_rxund = 0;
    check_state("R7 rx flags cleared");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op; op = $urandom_range(0, 9);
      case (op)
        0, 1: push_tx(8'($urandom));
        2, 3: eng_push(8'($urandom));
        4, 5: pop_rx("R5 random pop");
        6, 7: eng_take("R3 random take");
        8: begin
          logic [31:0] w; w = $urandom;
          case (w[1:0])
            2'd0: begin wr(8'h04, w); if (w[0]) m_rxovf = 0; if (w[3]) m_txovf = 0; if (w[6]) m_rxund = 0; end
            2'd1: begin wr(8'h08, w); m_mask = m_mask | w[6:0]; end
            2'd2: begin wr(8'h0C, w); m_mask = m_mask & ~w[6:0]; end
            default: begin wr(8'h14, w); m_run = w[0]; end
          endcase
        end
        default: begin rd(8'h10, bus_wdata); chk("R8 random mask", bus_wdata, {25'd0, m_mask}); end
      endcase
      check_state("R9 R11 random");
    end
    finish_up();
  end
endmodule